// File: doc/BRIEF.md
# Soft-Start and Overcurrent Hiccup Sequencer

This block sequences the start-up of a switching regulator's pulse logic and its recovery from overcurrent events. It keeps a digital soft-start level that stands in for the charge on a soft-start capacitor. The level is raised by a fixed charge step and lowered by a much larger discharge step on each clock. The level limits the error-amplifier command that the pulse-width comparator sees. The block also produces an output-enable that gates the pulse drivers, and a fault-latch flag.

The pulse logic may run only when both the main supply and the reference report good. After that, the level climbs from zero to a full constant. An overcurrent trip drops the enable in the same cycle and latches a fault. Recovery starts only after the level has first reached full and then fallen below a restart constant. This gives a bounded hiccup period when a short persists. If the trip is still present at the restart point, the level parks at zero until the trip goes away. A fresh soft-start then begins from the level the ramp has reached.

Top module: `ss_fault_seq`

## Requirements
- R1: While `vcc_ok` or `vref_ok` is low, the next edge puts the sequencer in the lockout state (code 0) with `ss_level` 0 and `fault_latched` 0. `out_en` is 0 whenever either flag is low.
- R2: In lockout with both supply flags high, the next edge enters the ramp state (code 1). Each further edge in ramp raises `ss_level` by CHG_STEP, saturating at FULL_LVL. The edge that makes the level equal to FULL_LVL also enters the run state (code 2).
- R3: `ea_clamped` always equals the smaller of `ea_cmd` and `ss_level`.
- R4: While `oc_trip` is high, `out_en` is 0 in the same cycle. An edge that samples `oc_trip` high in ramp or run sets `fault_latched`.
- R5: In the fault-discharge state (code 4), each edge that does not restart the sequence lowers `ss_level` by DIS_STEP, with a floor of 0.
- R6: A trip sampled in the ramp state leads to the fault-charge state (code 3). Charging by CHG_STEP continues there until FULL_LVL is reached, and that edge enters fault-discharge.
- R7: In fault-discharge, an edge with `ss_level` below RESTART_LVL and `oc_trip` low enters the ramp state. That edge keeps the current level and clears `fault_latched`.
- R8: While `oc_trip` stays high, the sequencer remains in fault-discharge, with the level ending at 0.
- R9: `out_en` is 1 only in the ramp or run state, with both supply flags high and `oc_trip` low. It is therefore 0 from a trip until the latch clears.
- R10: In the run state with no trip, `ss_level` stays at FULL_LVL.
- R11: A trip sampled in run enters fault-discharge at the next edge, with the level still at FULL_LVL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_ok | input | 1 | Main supply above its lockout threshold |
| vref_ok | input | 1 | Reference supply good |
| oc_trip | input | 1 | Overcurrent comparator output |
| ea_cmd | input | SS_W | Error-amplifier command |
| ss_level | output | SS_W | Soft-start level |
| ea_clamped | output | SS_W | Command limited to the soft-start level |
| out_en | output | 1 | Enable for the pulse drivers |
| fault_latched | output | 1 | Fault latch status |
| seq_state | output | 3 | Sequencer state code (0 lockout, 1 ramp, 2 run, 3 fault-charge, 4 fault-discharge) |

## Verification
The bench builds the block with an 8-bit level and a charge step of 4. It uses a discharge step of 28, a full level of 200 and a restart level of 20. With these values a full ramp takes 50 edges and a discharge from full takes seven steps. Every state is therefore reached within a few hundred cycles. The discharge sequence 200, 172, ..., 4 lands below the restart level without hitting zero. This separates the restart-from-current-level path from the floor-at-zero path used when the trip persists.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_LOCKOUT    = 3'd0,
        SEQ_RAMP       = 3'd1,
        SEQ_RUN        = 3'd2,
        SEQ_FLT_CHARGE = 3'd3,
        SEQ_FLT_DRAIN  = 3'd4
    } seq_state_e;

endpackage

// File: rtl/ss_level_step.sv
module ss_level_step #(
    parameter int W    = 12,
    parameter int CHG  = 9,
    parameter int DIS  = 250,
    parameter int FULL = 4000
) (
    input  logic [W-1:0] lvl_i,
    input  logic         charge_i,
    input  logic         drain_i,
    output logic [W-1:0] lvl_o,
    output logic         full_o
);
    localparam logic [W:0]   CHG_X  = (W+1)'(CHG);
    localparam logic [W:0]   FULL_X = (W+1)'(FULL);
    localparam logic [W-1:0] FULL_L = W'(FULL);
    localparam logic [W-1:0] DIS_L  = W'(DIS);

    logic [W:0] sum;

    always_comb begin
        sum = {1'b0, lvl_i} + CHG_X;
        if (charge_i) begin
            lvl_o = (sum >= FULL_X) ? FULL_L : sum[W-1:0];
        end else if (drain_i) begin
            lvl_o = (lvl_i <= DIS_L) ? '0 : (lvl_i - DIS_L);
        end else begin
            lvl_o = lvl_i;
        end
        full_o = (lvl_o == FULL_L);
    end
endmodule

// File: rtl/ss_cmd_clamp.sv
module ss_cmd_clamp #(
    parameter int W = 12
) (
    input  logic [W-1:0] cmd_i,
    input  logic [W-1:0] limit_i,
    output logic [W-1:0] cmd_o
);
    always_comb begin
        cmd_o = (cmd_i < limit_i) ? cmd_i : limit_i;
    end
endmodule

// File: rtl/ss_fault_seq.sv
module ss_fault_seq
    import ss_seq_pkg::*;
#(
    parameter int SS_W        = 12,
    parameter int CHG_STEP    = 9,
    parameter int DIS_STEP    = 250,
    parameter int FULL_LVL    = 4000,
    parameter int RESTART_LVL = 400
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vcc_ok,
    input  logic            vref_ok,
    input  logic            oc_trip,
    input  logic [SS_W-1:0] ea_cmd,
    output logic [SS_W-1:0] ss_level,
    output logic [SS_W-1:0] ea_clamped,
    output logic            out_en,
    output logic            fault_latched,
    output logic [2:0]      seq_state
);
    localparam logic [SS_W-1:0] RESTART_L = SS_W'(RESTART_LVL);

    typedef struct packed {
        seq_state_e      state;
        logic [SS_W-1:0] level;
    } seq_regs_t;

    seq_regs_t       cur_q, nxt_d;
    logic            supply_ok;
    logic            chg_en, drn_en;
    logic [SS_W-1:0] step_lvl;
    logic            step_full;

    assign supply_ok = vcc_ok & vref_ok;

    always_comb begin
        chg_en = (cur_q.state == SEQ_RAMP) || (cur_q.state == SEQ_FLT_CHARGE);
        drn_en = (cur_q.state == SEQ_FLT_DRAIN);
    end

    ss_level_step #(
        .W    (SS_W),
        .CHG  (CHG_STEP),
        .DIS  (DIS_STEP),
        .FULL (FULL_LVL)
    ) u_step (
        .lvl_i    (cur_q.level),
        .charge_i (chg_en),
        .drain_i  (drn_en),
        .lvl_o    (step_lvl),
        .full_o   (step_full)
    );

    always_comb begin
        nxt_d = cur_q;
        if (!supply_ok) begin
            nxt_d.state = SEQ_LOCKOUT;
            nxt_d.level = '0;
        end else begin
            unique case (cur_q.state)
                SEQ_LOCKOUT: begin
                    nxt_d.state = SEQ_RAMP;
                    nxt_d.level = '0;
                end
                SEQ_RAMP: begin
                    nxt_d.level = step_lvl;
                    if (oc_trip) begin
                        nxt_d.state = step_full ? SEQ_FLT_DRAIN : SEQ_FLT_CHARGE;
                    end else begin
                        nxt_d.state = step_full ? SEQ_RUN : SEQ_RAMP;
                    end
                end
                SEQ_RUN: begin
                    if (oc_trip) nxt_d.state = SEQ_FLT_DRAIN;
                end
                SEQ_FLT_CHARGE: begin
                    nxt_d.level = step_lvl;
                    if (step_full) nxt_d.state = SEQ_FLT_DRAIN;
                end
                SEQ_FLT_DRAIN: begin
                    if ((cur_q.level < RESTART_L) && !oc_trip) begin
                        nxt_d.state = SEQ_RAMP;
                    end else begin
                        nxt_d.level = step_lvl;
                    end
                end
                default: begin
                    nxt_d.state = SEQ_LOCKOUT;
                    nxt_d.level = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state <= SEQ_LOCKOUT;
            cur_q.level <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    ss_cmd_clamp #(
        .W (SS_W)
    ) u_clamp (
        .cmd_i   (ea_cmd),
        .limit_i (cur_q.level),
        .cmd_o   (ea_clamped)
    );

    assign ss_level      = cur_q.level;
    assign seq_state     = cur_q.state;
    assign fault_latched = (cur_q.state == SEQ_FLT_CHARGE) || (cur_q.state == SEQ_FLT_DRAIN);
    assign out_en        = supply_ok && !oc_trip &&
                           ((cur_q.state == SEQ_RAMP) || (cur_q.state == SEQ_RUN));
endmodule

module ss_fault_seq_chk #(
    parameter int SS_W        = 12,
    parameter int DIS_STEP    = 250,
    parameter int FULL_LVL    = 4000,
    parameter int RESTART_LVL = 400
) (
    input logic            clk,
    input logic            rst_n,
    input logic            vcc_ok,
    input logic            vref_ok,
    input logic            oc_trip,
    input logic [SS_W-1:0] ea_cmd,
    input logic [SS_W-1:0] ss_level,
    input logic [SS_W-1:0] ea_clamped,
    input logic            out_en,
    input logic            fault_latched,
    input logic [2:0]      seq_state
);
    // R1
    lockout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(vcc_ok && vref_ok) |=> (seq_state == 3'd0 && ss_level == '0 && !fault_latched));

    // R3
    clamp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ea_clamped <= ea_cmd) && (ea_clamped <= ss_level));

    // R4
    trip_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oc_trip |-> !out_en);

    // R5
    drain_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_ok && vref_ok && seq_state == 3'd4 && oc_trip && int'(ss_level) >= DIS_STEP)
        |=> (int'(ss_level) == int'($past(ss_level)) - DIS_STEP));

    // R6
    charge_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_ok && vref_ok && seq_state == 3'd3) |=> (seq_state == 3'd3 || seq_state == 3'd4));

    // R7
    latch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_ok && vref_ok && seq_state == 3'd4 && !oc_trip && int'(ss_level) < RESTART_LVL)
        |=> (!fault_latched && seq_state == 3'd1 && $stable(ss_level)));

    // R9
    enable_states_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> (seq_state == 3'd1 || seq_state == 3'd2));

    // R10
    run_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 3'd2) |-> (int'(ss_level) == FULL_LVL));
endmodule

bind ss_fault_seq ss_fault_seq_chk #(
    .SS_W        (SS_W),
    .DIS_STEP    (DIS_STEP),
    .FULL_LVL    (FULL_LVL),
    .RESTART_LVL (RESTART_LVL)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .vcc_ok        (vcc_ok),
    .vref_ok       (vref_ok),
    .oc_trip       (oc_trip),
    .ea_cmd        (ea_cmd),
    .ss_level      (ss_level),
    .ea_clamped    (ea_clamped),
    .out_en        (out_en),
    .fault_latched (fault_latched),
    .seq_state     (seq_state)
);

// File: tb/ss_fault_seq_tb.sv
module ss_fault_seq_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         vcc_ok = 1'b0;
    logic         vref_ok = 1'b0;
    logic         oc_trip = 1'b0;
    logic [W-1:0] ea_cmd = '0;
    logic [W-1:0] ss_level;
    logic [W-1:0] ea_clamped;
    logic         out_en;
    logic         fault_latched;
    logic [2:0]   seq_state;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ss_fault_seq #(
        .SS_W(W), .CHG_STEP(4), .DIS_STEP(28), .FULL_LVL(200), .RESTART_LVL(20)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .vref_ok(vref_ok),
        .oc_trip(oc_trip), .ea_cmd(ea_cmd), .ss_level(ss_level),
        .ea_clamped(ea_clamped), .out_en(out_en),
        .fault_latched(fault_latched), .seq_state(seq_state)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one rising edge, then return at the following falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic edges_until_state(int st, output int n);
        n = 0;
        while (int'(seq_state) != st && n < 1000) begin
            step();
            n++;
        end
    endtask

    task automatic t_reset();
        chk("R1 reset state", int'(seq_state), 0);
        chk("R1 reset level", int'(ss_level), 0);
        chk("R1 reset out_en", int'(out_en), 0);
        chk("R1 reset fault", int'(fault_latched), 0);
    endtask

    task automatic t_partial_supply();
        vcc_ok = 1'b1;
        vref_ok = 1'b0;
        repeat (10) step();
        chk("R1 vref low state", int'(seq_state), 0);
        chk("R1 vref low level", int'(ss_level), 0);
        chk("R1 vref low out_en", int'(out_en), 0);
    endtask

    task automatic t_startup();
        int n;
        vref_ok = 1'b1;
        step();
        chk("R2 enter ramp", int'(seq_state), 1);
        chk("R2 ramp start level", int'(ss_level), 0);
        step();
        step();
        chk("R2 level after two steps", int'(ss_level), 8);
        chk("R9 out_en in ramp", int'(out_en), 1);
        ea_cmd = 8'd255;
        #1;
        chk("R3 clamp to level", int'(ea_clamped), 8);
        ea_cmd = 8'd5;
        #1;
        chk("R3 command below level", int'(ea_clamped), 5);
        edges_until_state(2, n);
        chk("R2 edges to full", n, 48);
        chk("R2 full level", int'(ss_level), 200);
        repeat (5) step();
        chk("R10 run holds full", int'(ss_level), 200);
        ea_cmd = 8'd100;
        #1;
        chk("R3 run command passes", int'(ea_clamped), 100);
        ea_cmd = 8'd255;
        #1;
        chk("R3 run clamp at full", int'(ea_clamped), 200);
    endtask

    task automatic t_run_trip();
        oc_trip = 1'b1;
        #1;
        chk("R4 out_en drops same cycle", int'(out_en), 0);
        step();
        oc_trip = 1'b0;
        chk("R11 run trip to drain", int'(seq_state), 4);
        chk("R11 level at full", int'(ss_level), 200);
        chk("R4 latch set", int'(fault_latched), 1);
        for (int k = 1; k <= 7; k++) begin
            step();
            chk("R5 drain step", int'(ss_level), 200 - 28 * k);
            chk("R9 no enable in fault", int'(out_en), 0);
        end
        step();
        chk("R7 restart state", int'(seq_state), 1);
        chk("R7 restart keeps level", int'(ss_level), 4);
        chk("R7 latch cleared", int'(fault_latched), 0);
    endtask

    task automatic t_ramp_trip();
        int n;
        step();
        step();
        chk("R2 ramp from restart", int'(ss_level), 12);
        oc_trip = 1'b1;
        step();
        oc_trip = 1'b0;
        chk("R6 fault charge state", int'(seq_state), 3);
        chk("R6 charging continues", int'(ss_level), 16);
        chk("R4 latch set mid ramp", int'(fault_latched), 1);
        chk("R9 no enable in fault charge", int'(out_en), 0);
        edges_until_state(4, n);
        chk("R6 edges to full", n, 46);
        chk("R6 full before drain", int'(ss_level), 200);
        edges_until_state(1, n);
        chk("R7 restart after drain", n, 8);
    endtask

    task automatic t_held_trip();
        int n;
        edges_until_state(2, n);
        oc_trip = 1'b1;
        repeat (25) step();
        chk("R8 held trip state", int'(seq_state), 4);
        chk("R8 held trip level", int'(ss_level), 0);
        chk("R5 floor at zero", int'(fault_latched), 1);
        oc_trip = 1'b0;
        step();
        chk("R7 release after hold", int'(seq_state), 1);
        chk("R7 latch clear after hold", int'(fault_latched), 0);
    endtask

    task automatic t_uvlo_in_fault();
        int n;
        edges_until_state(2, n);
        oc_trip = 1'b1;
        step();
        oc_trip = 1'b0;
        step();
        vref_ok = 1'b0;
        #1;
        chk("R1 out_en low on supply loss", int'(out_en), 0);
        step();
        chk("R1 lockout from fault", int'(seq_state), 0);
        chk("R1 level cleared", int'(ss_level), 0);
        chk("R1 fault cleared", int'(fault_latched), 0);
        vref_ok = 1'b1;
        step();
        chk("R2 restart after lockout", int'(seq_state), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_partial_supply();
        t_startup();
        t_run_trip();
        t_ramp_trip();
        t_held_trip();
        t_uvlo_in_fault();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule